// File: doc/BRIEF.md
# Selectable-Pin Edge Event Channel

This block watches one pin out of a bank of general-purpose inputs and turns a chosen transition on that pin into a sticky event flag and an interrupt request for an interrupt controller. Software picks the pin with a port bit and a pin number, picks the kind of transition (rising, falling, either, or none), and arms the channel with a mode bit. All of these sit in one packed configuration word. Each pin of the bank first passes through a two-flop synchroniser. The previous synchronised level of every pin is kept, so the block can detect a transition by comparing the current and previous samples of the selected pin.

When the configured transition is seen, the event flag is set and stays set until software writes a zero to the event register. The interrupt request is a level. It is high while the flag is set and the interrupt enable is on. The enable has its own set and clear registers, so software can change it without a read-modify-write.

Top module: `gpio_edge_event_ch`

## Requirements
- R1: After reset the configuration word reads 0, the interrupt enable reads 0, and both `evt_flag` and `irq` are 0.
- R2: The configuration word (address 0) keeps bit 0 as the mode (1 = watch input), bits 12:8 as the pin number, bit 13 as the port select and bits 17:16 as the polarity. Other bits read back as 0, so writing all ones reads back as 0x0003_3F01.
- R3: With polarity 1 in watch mode, a low-to-high transition of the selected pin sets the event flag and a high-to-low transition does not.
- R4: With polarity 2 in watch mode, a high-to-low transition sets the event flag and a low-to-high transition does not.
- R5: With polarity 3 in watch mode, a transition in either direction sets the event flag.
- R6: Polarity 0, or mode bit 0, never sets the event flag.
- R7: A pin change first sampled at rising clock edge n shows up on `evt_flag` just after edge n+2 and not before.
- R8: The event flag stays set until a write to the event register (address 3) with bit 0 clear. A write with bit 0 set leaves the flag unchanged. Reading address 3 returns the flag in bit 0.
- R9: Writing bit 0 = 1 to the enable-set register (address 1) turns the interrupt enable on, and writing bit 0 = 1 to the enable-clear register (address 2) turns it off. A write of bit 0 = 0 to either register has no effect. Addresses 1 and 2 both read the enable in bit 0.
- R10: `irq` is high exactly while the event flag and the interrupt enable are both set.
- R11: If a configured transition and a clearing write to the event register happen in the same cycle, the flag ends up set.
- R12: Arming the channel, or moving it to another pin, does not produce an event from a level that was already present on the pin.
- R13: Transitions on pins that are not selected, including the same pin number on the other port, do not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | PORT_CNT*PIN_CNT | Pin levels, port-major (port p pin q at bit p*PIN_CNT+q) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register index (0 config, 1 enable set, 2 enable clear, 3 event) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | 32 | Combinational read data |
| evt_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Level interrupt request |

## Verification
A fault in the stored previous-sample bank shows up as a flag that rises after arming or after a pin switch with no transition on the pin. It also shows up as a missed event that is visible three edges after the pin change. A polarity decode swapped or mis-positioned in the configuration word makes the flag follow the wrong transition on the next pin change. It also makes the readback of the configuration word wrong at once. A wrong priority between set and clear is visible one edge after the colliding write. A faulty enable register is visible on `irq` one edge after the write.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   // configuration word field positions (decoded by software)
   localparam int MODE_BIT = 0;
   localparam int PIN_LSB  = 8;
   localparam int PIN_W    = 5;
   localparam int PORT_BIT = 13;
   localparam int POL_LSB  = 16;
   localparam int POL_W    = 2;
   localparam int DATA_W   = 32;

   typedef enum logic [1:0] {
      POL_OFF  = 2'd0,
      POL_RISE = 2'd1,
      POL_FALL = 2'd2,
      POL_ANY  = 2'd3
   } pol_e;

   typedef enum logic [1:0] {
      RG_CFG   = 2'd0,
      RG_ENSET = 2'd1,
      RG_ENCLR = 2'd2,
      RG_EVT   = 2'd3
   } reg_e;

   typedef struct packed {
      logic             watch;
      logic             port;
      logic [PIN_W-1:0] pin;
      pol_e             pol;
   } cfg_t;

   localparam cfg_t CFG_RST = '{watch: 1'b0, port: 1'b0, pin: '0, pol: POL_OFF};

   function automatic cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
      cfg_t c;
      c.watch = w[MODE_BIT];
      c.port  = w[PORT_BIT];
      c.pin   = w[PIN_LSB +: PIN_W];
      c.pol   = pol_e'(w[POL_LSB +: POL_W]);
      return c;
   endfunction

   function automatic logic [DATA_W-1:0] cfg_pack(input cfg_t c);
      logic [DATA_W-1:0] w;
      w = '0;
      w[MODE_BIT]            = c.watch;
      w[PORT_BIT]            = c.port;
      w[PIN_LSB +: PIN_W]    = c.pin;
      w[POL_LSB +: POL_W]    = c.pol;
      return w;
   endfunction
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
   parameter int WIDTH  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync_bank: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            if (s == 0) chain[s] <= d_async;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
   import gpio_evt_pkg::*;
#(
   parameter int PORT_CNT = 2,
   parameter int PIN_CNT  = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PORT_CNT*PIN_CNT-1:0] lvl,
   input  cfg_t                        cfg,
   output logic                        edge_hit
);
   localparam int N = PORT_CNT * PIN_CNT;

   // previous level of every pin, tracked in all modes
   logic [N-1:0] prev_lvl;
   logic         cur, prv, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= '0;
      else        prev_lvl <= lvl;
   end

   always_comb begin
      cur = 1'b0;
      prv = 1'b0;
      for (int p = 0; p < PORT_CNT; p++) begin
         for (int q = 0; q < PIN_CNT; q++) begin
            if (cfg.port == p[0] && cfg.pin == q[PIN_W-1:0]) begin
               cur = lvl[p*PIN_CNT+q];
               prv = prev_lvl[p*PIN_CNT+q];
            end
         end
      end
   end

   assign rise = cur & ~prv;
   assign fall = ~cur & prv;

   always_comb begin
      edge_hit = 1'b0;
      if (cfg.watch) begin
         unique case (cfg.pol)
            POL_RISE: edge_hit = rise;
            POL_FALL: edge_hit = fall;
            POL_ANY:  edge_hit = rise | fall;
            default:  edge_hit = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
   import gpio_evt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   input  logic              edge_hit,
   output logic [DATA_W-1:0] rd_data,
   output cfg_t              cfg,
   output logic              int_en,
   output logic              evt_flag
);
   logic wr_cfg, wr_set, wr_clr, wr_evt;

   assign wr_cfg = wr_en && (reg_e'(wr_addr) == RG_CFG);
   assign wr_set = wr_en && (reg_e'(wr_addr) == RG_ENSET) && wr_data[0];
   assign wr_clr = wr_en && (reg_e'(wr_addr) == RG_ENCLR) && wr_data[0];
   assign wr_evt = wr_en && (reg_e'(wr_addr) == RG_EVT) && !wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= CFG_RST;
         int_en <= 1'b0;
      end else begin
         if (wr_cfg) cfg <= cfg_unpack(wr_data);
         if (wr_set)      int_en <= 1'b1;
         else if (wr_clr) int_en <= 1'b0;
      end
   end

   // a new edge takes priority over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        evt_flag <= 1'b0;
      else if (edge_hit) evt_flag <= 1'b1;
      else if (wr_evt)   evt_flag <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      unique case (reg_e'(rd_addr))
         RG_CFG:   rd_data = cfg_pack(cfg);
         RG_ENSET,
         RG_ENCLR: rd_data[0] = int_en;
         RG_EVT:   rd_data[0] = evt_flag;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_event_ch.sv
module gpio_edge_event_ch
   import gpio_evt_pkg::*;
#(
   parameter int PORT_CNT    = 2,
   parameter int PIN_CNT     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PORT_CNT*PIN_CNT-1:0] pins_in,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [1:0]                  rd_addr,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        evt_flag,
   output logic                        irq
);
   localparam int N = PORT_CNT * PIN_CNT;

   if (PORT_CNT < 1 || PORT_CNT > 2) begin : g_bad_ports
      $error("gpio_edge_event_ch: PORT_CNT must be 1 or 2");
   end
   if (PIN_CNT < 1 || PIN_CNT > (1 << PIN_W)) begin : g_bad_pins
      $error("gpio_edge_event_ch: PIN_CNT out of range");
   end

   logic [N-1:0] lvl_sync;
   cfg_t         cfg;
   logic         edge_hit;
   logic         int_en;

   gpio_sync_bank #(.WIDTH(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_in),
      .d_sync  (lvl_sync)
   );

   gpio_edge_detect #(.PORT_CNT(PORT_CNT), .PIN_CNT(PIN_CNT)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .cfg      (cfg),
      .edge_hit (edge_hit)
   );

   gpio_evt_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .edge_hit (edge_hit),
      .rd_data  (rd_data),
      .cfg      (cfg),
      .int_en   (int_en),
      .evt_flag (evt_flag)
   );

   assign irq = evt_flag & int_en;
endmodule

// File: rtl/gpio_edge_event_ch_chk.sv
module gpio_edge_event_ch_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [1:0]  wr_addr,
   input logic [31:0] wr_data,
   input logic        edge_hit,
   input logic        int_en,
   input logic        evt_flag,
   input logic        irq
);
   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !(wr_en && wr_addr == 2'd3 && !wr_data[0])) |=> evt_flag);

   // R11
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> evt_flag);

   // R3
   flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_flag) |-> $past(edge_hit));

   // R9
   enset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1 && !wr_data[0]) |=> $stable(int_en));

   // R9
   enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && wr_data[0]) |=> !int_en);

   // R10
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(edge_hit) || $past(wr_en && wr_addr == 2'd1 && wr_data[0])));
endmodule

bind gpio_edge_event_ch gpio_edge_event_ch_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .edge_hit (edge_hit),
   .int_en   (int_en),
   .evt_flag (evt_flag),
   .irq      (irq)
);

// File: tb/sim_gpio_edge_event_ch.sv
module sim_gpio_edge_event_ch;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;
   localparam int SEL = 37; // port 1, pin 5

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pins_in = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        evt_flag, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_event_ch u0 (
      .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_flag(evt_flag), .irq(irq)
   );

   // vector: {watch, pol[1:0], start, end, expected}
   localparam int NV = 9;
   localparam logic [5:0] VEC [NV] = '{
      6'b1_01_0_1_1, // R3 rise seen
      6'b1_01_1_0_0, // R3 fall ignored
      6'b1_10_1_0_1, // R4 fall seen
      6'b1_10_0_1_0, // R4 rise ignored
      6'b1_11_0_1_1, // R5 rise
      6'b1_11_1_0_1, // R5 fall
      6'b1_00_0_1_0, // R6 pol 0
      6'b1_00_1_0_0, // R6 pol 0
      6'b0_01_0_1_0  // R6 mode 0
   };

   function automatic logic [31:0] cfgw(input logic watch, input logic port,
                                        input logic [4:0] pin, input logic [1:0] pol);
      return {14'd0, pol, 2'd0, port, pin, 7'd0, watch};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic clocks(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 flag", {31'd0, evt_flag}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd(2'd0, r); check("R1 cfg", r, 32'd0);
      rd(2'd1, r); check("R1 en", r, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 field layout readback
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, r); check("R2 cfg readback", r, 32'h0003_3F01);

      // table walk: R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, cfgw(VEC[i][5], 1'b1, 5'd5, VEC[i][4:3]));
         pins_in[SEL] = VEC[i][2];
         clocks(4);
         wr(2'd3, 32'd0);
         pins_in[SEL] = VEC[i][1];
         clocks(3);
         check($sformatf("R3/R4/R5/R6 vector %0d", i), {31'd0, evt_flag}, {31'd0, VEC[i][0]});
      end

      // R7 latency, R10 irq
      wr(2'd0, cfgw(1'b1, 1'b1, 5'd5, 2'd1));
      pins_in[SEL] = 1'b0;
      clocks(4);
      wr(2'd3, 32'd0);
      wr(2'd1, 32'd1);
      pins_in[SEL] = 1'b1;
      clocks(2);
      check("R7 not yet", {31'd0, evt_flag}, 32'd0);
      check("R10 irq low", {31'd0, irq}, 32'd0);
      clocks(1);
      check("R7 set", {31'd0, evt_flag}, 32'd1);
      check("R10 irq high", {31'd0, irq}, 32'd1);

      // R8 write of 1 keeps flag
      wr(2'd3, 32'd1);
      rd(2'd3, r); check("R8 write 1 ignored", r, 32'd1);
      // R9 enable-set write 0 ignored
      wr(2'd1, 32'd0);
      check("R9 set 0 ignored", {31'd0, irq}, 32'd1);
      wr(2'd2, 32'd1);
      check("R10 irq off after clear", {31'd0, irq}, 32'd0);
      check("R10 flag kept", {31'd0, evt_flag}, 32'd1);
      rd(2'd2, r); check("R9 en read", r, 32'd0);
      wr(2'd2, 32'd0);
      wr(2'd1, 32'd0);
      check("R9 writes of 0 ignored", {31'd0, irq}, 32'd0);
      wr(2'd1, 32'd1);
      check("R9 set 1", {31'd0, irq}, 32'd1);
      wr(2'd3, 32'd0);
      check("R8 clear", {31'd0, evt_flag}, 32'd0);
      check("R10 irq follows flag", {31'd0, irq}, 32'd0);

      // R11 edge vs clear in the same cycle
      wr(2'd0, cfgw(1'b1, 1'b1, 5'd5, 2'd3));
      pins_in[SEL] = 1'b0;
      clocks(4);
      check("R11 setup", {31'd0, evt_flag}, 32'd1);
      pins_in[SEL] = 1'b1;
      clocks(2);
      wr(2'd3, 32'd0);
      check("R11 edge wins", {31'd0, evt_flag}, 32'd1);
      wr(2'd3, 32'd0);
      check("R11 plain clear", {31'd0, evt_flag}, 32'd0);

      // R12 arming with level already present
      wr(2'd0, cfgw(1'b0, 1'b1, 5'd5, 2'd1));
      pins_in[SEL] = 1'b0;
      clocks(4);
      pins_in[SEL] = 1'b1;
      clocks(4);
      check("R12 idle no event", {31'd0, evt_flag}, 32'd0);
      wr(2'd0, cfgw(1'b1, 1'b1, 5'd5, 2'd3));
      clocks(4);
      check("R12 arm no event", {31'd0, evt_flag}, 32'd0);
      pins_in[36] = 1'b0;
      clocks(4);
      wr(2'd0, cfgw(1'b1, 1'b1, 5'd4, 2'd3));
      clocks(4);
      check("R12 pin switch no event", {31'd0, evt_flag}, 32'd0);

      // R13 other pins ignored
      wr(2'd0, cfgw(1'b1, 1'b1, 5'd5, 2'd3));
      clocks(2);
      pins_in[5]  = ~pins_in[5];
      pins_in[38] = ~pins_in[38];
      clocks(4);
      pins_in[5]  = ~pins_in[5];
      clocks(4);
      check("R13 other pins", {31'd0, evt_flag}, 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule